// File: doc/BRIEF.md
# Inversionless Euclidean Key-Equation Solver

This block finds the error-locator and error-evaluator polynomials of a Reed-Solomon (255,239) decoder over GF(2^8), which corrects up to t = 8 symbol errors. A decoder front end presents the sixteen syndromes together with a one-cycle start strobe. The solver then runs a fixed 2t iterations and raises a one-cycle done strobe. From that cycle until the next start, the coefficient outputs hold the result, ready for a root search and an error-value stage that sit outside this block.

The working state is one remainder register with 3t+1 coefficient cells and one scratch register of the same size. The lower cells of the remainder hold the evaluator terms and the upper cells hold the locator. The coefficient in cell 0 is the leading coefficient. Each iteration is in one of two states:

- **S0**: the leading coefficient is nonzero. The iteration does an inversionless cross-multiply update of the form `scale*R - lead*Q`, which cancels the old leading term to zero.
- **S1**: the leading coefficient is zero. The iteration only shifts the remainder down one cell, which removes the zero.

Roles swap only in an S0 iteration. The swap is decided by a small balance counter, not by comparing polynomial degrees, and the run always ends after 2t iterations. The processing element is recursive, and its multiplier products are registered, so one iteration takes two clocks.

Top module: `rs_keq_solver`

## Requirements
- R1: Timing of a solve. A start sampled on a rising edge begins a solve. `done` goes high on the 32nd rising edge after that edge, which is 2 clocks for each of the 16 iterations.
- R2: Done strobe width. `done` stays high for exactly one clock cycle.
- R3: Locator result. `lambda[8j+:8]` holds locator coefficient Λ_j for j = 0..8, and Λ_0 is nonzero. Syndromes are packed as `syn[8i+:8] = S_i = r(α^(i+1))`, where α = 0x02 is a root of x^8+x^4+x^3+x^2+1. For ν ≤ 8 errors, Λ has degree ν. Among the 255 points α^(-p), Λ vanishes exactly at those where p is an error position.
- R4: Evaluator result. `omega[8i+:8]` equals the coefficient of x^(16+i) in Λ(x)·S(x), where S(x) = Σ S_i x^i, for i = 0..7.
- R5: All-zero syndromes. They give `lambda` = 0x01 in its low byte, zero in every other locator byte, and all-zero `omega`.
- R6: Holding the result. From the `done` cycle until the next start, `lambda` and `omega` stay constant, whatever happens on `syn`.
- R7: Restart. A start during a solve abandons that solve: no `done` comes from it. A new solve begins on the new syndromes, and its timing follows R1.
- R8: Reset state. After reset, `done` is low and `lambda` and `omega` are all zero.
- R9: Edge cases. A single error at position 0 or at position 254 is located correctly. A pattern of exactly t = 8 errors is also located correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that loads the syndromes and starts a solve |
| syn | input | 128 | Syndromes; S_i is in bits [8i+7:8i] |
| done | output | 1 | One-cycle strobe that marks a finished solve |
| lambda | output | 72 | Locator coefficients; Λ_j is in bits [8j+7:8j] |
| omega | output | 64 | Evaluator coefficients; Ω_i is in bits [8i+7:8i] |

## Verification
The bound checker covers the timing and control properties on every cycle:
- the exact start-to-done latency;
- the single-cycle width of `done`;
- a nonzero locator constant term whenever `done` is high;
- the outputs holding after `done`;
- a restart clearing a pending `done`.

The bench's scenarios are needed for the algebraic results. For error patterns whose answers are known, it checks that the roots of the locator land exactly on the injected error positions. It also checks that the evaluator matches the high half of Λ·S. It covers the all-zero input, the extreme error positions and the full t-error pattern.

// File: rtl/rs_keq_solver.sv
module rs_keq_solver #(
  parameter int SYM_W = 8,
  parameter int T     = 8,
  parameter int POLY  = 285
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2*T*SYM_W-1:0]     syn,
  output logic                     done,
  output logic [(T+1)*SYM_W-1:0]   lambda,
  output logic [T*SYM_W-1:0]       omega
);
  localparam int NSYN  = 2 * T;
  localparam int NCELL = 3 * T + 1;
  localparam int ITERS = 2 * T;
  localparam int IW    = $clog2(ITERS);
  localparam int KW    = IW + 2;
  localparam logic [SYM_W-1:0] PLOW = SYM_W'(POLY);

  function automatic logic [SYM_W-1:0] gmul(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p;
    logic [SYM_W-1:0] x;
    p = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ PLOW) : (x << 1);
    end
    return p;
  endfunction

  logic [SYM_W-1:0] rem  [NCELL];
  logic [SYM_W-1:0] scr  [NCELL];
  logic [SYM_W-1:0] rdn  [NCELL];
  logic [SYM_W-1:0] ld   [NCELL];
  logic [SYM_W-1:0] pa   [NCELL];
  logic [SYM_W-1:0] pb   [NCELL];
  logic [SYM_W-1:0] scale;
  logic signed [KW-1:0] bal;
  logic [IW-1:0] iter;
  logic busy, phase;

  wire lead_s0 = (rem[0] != '0);
  wire swap    = lead_s0 && !bal[KW-1];
  wire last    = (iter == IW'(ITERS - 1));

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    if (i < NCELL - 1) begin : g_dn
      assign rdn[i] = rem[i+1];
    end else begin : g_top
      assign rdn[i] = '0;
    end
    if (i < NSYN) begin : g_syn
      assign ld[i] = syn[i*SYM_W +: SYM_W];
    end else if (i == NCELL - 1) begin : g_one
      assign ld[i] = SYM_W'(1);
    end else begin : g_zero
      assign ld[i] = '0;
    end
  end

  for (genvar j = 0; j <= T; j++) begin : g_lam
    assign lambda[j*SYM_W +: SYM_W] = rem[T+j];
  end
  for (genvar j = 0; j < T; j++) begin : g_om
    assign omega[j*SYM_W +: SYM_W] = rem[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCELL; i++) begin
        rem[i] <= '0;
        scr[i] <= '0;
        pa[i]  <= '0;
        pb[i]  <= '0;
      end
      scale <= SYM_W'(1);
      bal   <= '0;
      iter  <= '0;
      busy  <= 1'b0;
      phase <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        for (int i = 0; i < NCELL; i++) begin
          rem[i] <= ld[i];
          scr[i] <= ld[i];
        end
        scale <= SYM_W'(1);
        bal   <= '0;
        iter  <= '0;
        phase <= 1'b0;
        busy  <= 1'b1;
      end else if (busy) begin
        if (!phase) begin
          for (int i = 0; i < NCELL; i++) begin
            pa[i] <= gmul(scale, rdn[i]);
            pb[i] <= gmul(rem[0], scr[i]);
          end
          phase <= 1'b1;
        end else begin
          for (int i = 0; i < NCELL; i++) begin
            rem[i] <= pa[i] ^ pb[i];
            if (swap) scr[i] <= rdn[i];
          end
          if (swap) begin
            scale <= rem[0];
            bal   <= -bal - KW'(1);
          end else begin
            bal   <= bal + KW'(1);
          end
          phase <= 1'b0;
          iter  <= iter + IW'(1);
          if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rs_keq_solver_chk.sv
module rs_keq_solver_chk #(
  parameter int SYM_W = 8,
  parameter int T     = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   done,
  input logic                   busy,
  input logic [(T+1)*SYM_W-1:0] lambda,
  input logic [T*SYM_W-1:0]     omega
);
  localparam int LAT = 4 * T;
  localparam int CW  = $clog2(LAT + 2);

  logic          run, hold;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hold <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      run  <= 1'b1;
      hold <= 1'b0;
      cnt  <= '0;
    end else begin
      if (run) cnt <= cnt + CW'(1);
      if (done) begin
        run  <= 1'b0;
        hold <= 1'b1;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run && cnt == CW'(LAT)));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_lead_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lambda[SYM_W-1:0] != '0));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !start) |=> ($stable(lambda) && $stable(omega)));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));
endmodule

bind rs_keq_solver rs_keq_solver_chk #(.SYM_W(SYM_W), .T(T)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
  .lambda(lambda), .omega(omega)
);

// File: tb/rs_keq_solver_tb_top.sv
module rs_keq_solver_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [127:0] syn = '0;
  logic done;
  logic [71:0] lambda;
  logic [63:0] omega;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  typedef struct {
    logic [127:0] s;
    int nerr;
    int pos [8];
    int sc;
  } item_t;

  item_t q [$];
  logic [71:0] last_lam;
  logic [63:0] last_om;

  rs_keq_solver dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .syn(syn),
    .done(done), .lambda(lambda), .omega(omega)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] apow(input int e);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < (e % 255); i++) r = gm(r, 8'h02);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input int n, input int p [8], input int v [8]);
    item_t it;
    logic [7:0] acc;
    it.nerr = n;
    it.pos = p;
    for (int i = 0; i < 16; i++) begin
      acc = 8'h00;
      for (int j = 0; j < n; j++)
        acc = acc ^ gm(v[j][7:0], apow(p[j] * (i + 1)));
      it.s[i*8 +: 8] = acc;
    end
    @(negedge clk);
    syn = it.s;
    start = 1'b1;
    it.sc = cyc;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    logic [7:0] lam [9];
    logic [7:0] sv;
    logic [7:0] ev;
    int roots;
    int deg;
    forever begin
      @(negedge clk);
      if (done) begin
        last_lam = lambda;
        last_om = omega;
        if (q.size() == 0) begin
          check(1'b0, "R7", "done with nothing pending", 1, 0);
        end else begin
          it = q.pop_front();
          check(cyc - it.sc == 33, "R1", "start-to-done edges", cyc - it.sc - 1, 32);
          for (int j = 0; j < 9; j++) lam[j] = lambda[j*8 +: 8];
          check(lam[0] != 8'h00, "R3", "locator constant term", lam[0], 1);
          deg = 0;
          for (int j = 0; j < 9; j++) if (lam[j] != 8'h00) deg = j;
          check(deg == it.nerr, "R3", "locator degree", deg, it.nerr);
          roots = 0;
          for (int p = 0; p < 255; p++) begin
            ev = 8'h00;
            for (int j = 0; j < 9; j++) ev = ev ^ gm(lam[j], apow(((255 - p) * j) % 255));
            if (ev == 8'h00) roots++;
          end
          check(roots == it.nerr, "R3", "root count", roots, it.nerr);
          for (int k = 0; k < it.nerr; k++) begin
            ev = 8'h00;
            for (int j = 0; j < 9; j++) ev = ev ^ gm(lam[j], apow(((255 - it.pos[k]) * j) % 255));
            check(ev == 8'h00, (it.pos[k] == 0 || it.pos[k] == 254) ? "R9" : "R3",
                  "locator at error position", ev, 0);
          end
          for (int i = 0; i < 8; i++) begin
            sv = 8'h00;
            for (int j = i + 1; j <= 8; j++) sv = sv ^ gm(lam[j], it.s[(16 + i - j)*8 +: 8]);
            check(omega[i*8 +: 8] == sv, "R4", "evaluator coefficient", omega[i*8 +: 8], sv);
          end
          if (it.nerr == 0) begin
            check(lambda == 72'h01, "R5", "locator for zero syndromes", lambda, 72'h01);
            check(omega == 64'h0, "R5", "evaluator for zero syndromes", omega, 0);
          end
        end
        @(negedge clk);
        check(!done, "R2", "done width", done, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p [8];
    int v [8];
    repeat (3) @(negedge clk);
    check(!done, "R8", "done after reset", done, 0);
    check(lambda == 72'h0, "R8", "lambda after reset", lambda, 0);
    check(omega == 64'h0, "R8", "omega after reset", omega, 0);
    rst_n = 1'b1;
    @(negedge clk);

    p = '{0, 0, 0, 0, 0, 0, 0, 0};
    v = '{0, 0, 0, 0, 0, 0, 0, 0};
    launch(0, p, v); drain();                     // R5

    p[0] = 0;   v[0] = 1;    launch(1, p, v); drain();   // R9 position 0
    p[0] = 254; v[0] = 255;  launch(1, p, v); drain();   // R9 position 254

    p = '{17, 200, 0, 0, 0, 0, 0, 0};
    v = '{8'h3C, 8'h81, 0, 0, 0, 0, 0, 0};
    launch(2, p, v); drain();                     // R3

    p = '{5, 99, 140, 231, 60, 0, 0, 0};
    v = '{8'h11, 8'h02, 8'hE7, 8'h5A, 8'hC3, 0, 0, 0};
    launch(5, p, v); drain();                     // R3, R4

    p = '{1, 33, 64, 97, 128, 161, 190, 253};
    v = '{8'h9F, 8'h01, 8'h44, 8'hB2, 8'h7E, 8'h23, 8'hD0, 8'h6B};
    launch(8, p, v); drain();                     // R9 full t errors

    // R7: restart mid-solve; the first solve must not report
    p = '{10, 20, 30, 0, 0, 0, 0, 0};
    v = '{8'h05, 8'h06, 8'h07, 0, 0, 0, 0, 0};
    launch(3, p, v);
    repeat (9) @(negedge clk);
    void'(q.pop_back());
    p = '{77, 150, 222, 3, 0, 0, 0, 0};
    v = '{8'hAA, 8'h55, 8'h0F, 8'hF0, 0, 0, 0, 0};
    launch(4, p, v); drain();

    // R6: outputs hold while syn changes without start
    repeat (4) @(negedge clk);
    syn = 128'hDEADBEEF_0BADF00D_12345678_9ABCDEF0;
    repeat (6) @(negedge clk);
    check(lambda == last_lam, "R6", "lambda held", lambda, last_lam);
    check(omega == last_om, "R6", "omega held", omega, last_om);
    check(!done, "R6", "no done without start", done, 0);

    // back-to-back solves, second starts right after the first done
    p = '{42, 43, 0, 0, 0, 0, 0, 0};
    v = '{8'h80, 8'h80, 0, 0, 0, 0, 0, 0};
    launch(2, p, v);
    while (q.size() != 0) @(negedge clk);
    p = '{250, 251, 252, 253, 254, 0, 0, 0};
    v = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 0, 0, 0};
    launch(5, p, v); drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule